// File: doc/BRIEF.md
# Inverted Page Table Address Translator

This block maps logical RAM addresses to physical RAM addresses through an inverted page table. The table has one slot per physical page, and there are 128 slots. Each slot holds the logical page that is placed on that physical page and a two-bit protection level. A slot is loaded by a single write whose bus address carries the whole entry, with the slot number in its low seven bits.

On a lookup request, every slot compares its logical page number with the page number of the request at the same time. The bit layout of both the logical and the physical page number inside a slot depends on the configured page size (4, 8, 16 or 32 KB). A slot can serve the access only if its protection level allows the access class:
- An untranslated access counts as supervisor.
- A translated access counts as OS when the OS-mode flag is set.
- Any other translated access counts as user.

The permitted matching slot with the lowest number supplies the physical page. When no slot can serve the access, the response is an abort.

The response is registered and appears on the clock edge after the request is sampled. The surrounding memory system uses it either to steer the RAM access or to raise a data abort.

Top module: `phys_page_xlate`

## Requirements
- R1: After reset no slot holds a mapping, so every lookup aborts until slots have been written.
- R2: A table write with `tbl_wr_en` high stores all 23 bits of `tbl_wr_addr` into the slot numbered `tbl_wr_addr[6:0]`. A later write to the same slot replaces the earlier contents.
- R3: Page size code 0 (4 KB). Logical page = {e[11:10], e[22:12]}, compared with address bits [24:12]. Physical page = e[6:0]. Physical address = {physical page, address[11:0]}.
- R4: Page size code 1 (8 KB). Logical page = {e[11:10], e[22:13]}, compared with address bits [24:13]. Physical page = {e[0], e[6:1]}. Physical address = {physical page, address[12:0]}.
- R5: Page size code 2 (16 KB). Logical page = {e[11:10], e[22:14]}, compared with address bits [24:14]. Physical page = {e[1:0], e[6:2]}. Physical address = {physical page, address[13:0]}.
- R6: Page size code 3 (32 KB). Logical page = {e[11:10], e[22:15]}, compared with address bits [24:15]. Physical page = {e[1], e[2], e[0], e[6:3]}. Physical address = {physical page, address[14:0]}.
- R7: Request address bits [31:25] have no effect on the lookup.
- R8: With `req_word` high, bits [1:0] of the returned physical address are zero. With `req_word` low, they equal request address bits [1:0].
- R9: An access with `req_user` low is supervisor class. It may read and write a matching slot at any protection level, whatever `cfg_os_mode` is.
- R10: An access with `req_user` and `cfg_os_mode` both high is OS class. It may read and write slots at levels 00 and 01, and may only read slots at levels 10 and 11. The protection level is e[9:8].
- R11: An access with `req_user` high and `cfg_os_mode` low is user class. It may read and write level 00 slots, may only read level 01 slots, and has no access to levels 10 and 11.
- R12: When several permitted slots match, the lowest-numbered one supplies the physical page.
- R13: `rsp_valid` is high exactly on the cycle after a sampled `req_valid`. `rsp_abort` is then high if and only if no permitted slot matched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_wr_en | input | 1 | Table write strobe |
| tbl_wr_addr | input | 23 | Address-encoded entry; bits [6:0] select the slot |
| cfg_page_sz | input | 2 | Page size code: 0 = 4 KB, 1 = 8 KB, 2 = 16 KB, 3 = 32 KB |
| cfg_os_mode | input | 1 | OS-mode flag from the control register |
| req_valid | input | 1 | Lookup request |
| req_addr | input | 32 | Logical access address |
| req_word | input | 1 | Word access (low two address bits cleared) |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is translated (user or OS class) |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_abort | output | 1 | No permitted mapping for the access |
| rsp_paddr | output | 22 | Physical RAM byte address |

## Verification
A lookup sampled on one rising edge produces `rsp_valid`, `rsp_abort` and `rsp_paddr` on the next rising edge. A table write sampled on an edge is seen by any request sampled on a later edge.

The bench drives every input just after a falling edge and reads the response at the following falling edge, which lies midway through the cycle in which the result is due. It never issues a lookup in the same cycle as the write it depends on. Because the page size and OS flag are held with the request, each expected value is computed from the bench's model of the table as it stood at the sampling edge.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

  localparam int NUM_ENT = 128;
  localparam int IDX_W   = $clog2(NUM_ENT);
  localparam int ENT_W   = 23;
  localparam int LA_W    = 25;
  localparam int LPN_W   = 13;
  localparam int OFF_W   = 15;
  localparam int PA_W    = 22;
  localparam int LVL_LSB = 8;

  typedef enum logic [1:0] {
    PG_4K  = 2'd0,
    PG_8K  = 2'd1,
    PG_16K = 2'd2,
    PG_32K = 2'd3
  } pg_size_e;

  typedef enum logic [1:0] {
    AM_SUP = 2'd0,
    AM_OS  = 2'd1,
    AM_USR = 2'd2
  } acc_mode_e;

  // Logical page held by a slot, zero-extended to the 4 KB width.
  function automatic logic [LPN_W-1:0] ent_lpn(logic [ENT_W-1:0] e, pg_size_e sz);
    logic [LPN_W-1:0] r;
    unique case (sz)
      PG_4K:   r = {e[11:10], e[22:12]};
      PG_8K:   r = {1'b0, e[11:10], e[22:13]};
      PG_16K:  r = {2'b0, e[11:10], e[22:14]};
      default: r = {3'b0, e[11:10], e[22:15]};
    endcase
    return r;
  endfunction

  // Physical page held by a slot; the scrambling depends on page size.
  function automatic logic [IDX_W-1:0] ent_ppn(logic [ENT_W-1:0] e, pg_size_e sz);
    logic [IDX_W-1:0] r;
    unique case (sz)
      PG_4K:   r = e[6:0];
      PG_8K:   r = {e[0], e[6:1]};
      PG_16K:  r = {e[1:0], e[6:2]};
      default: r = {e[1], e[2], e[0], e[6:3]};
    endcase
    return r;
  endfunction

  function automatic logic [LPN_W-1:0] la_page(logic [LA_W-1:0] la, pg_size_e sz);
    logic [LPN_W-1:0] r;
    unique case (sz)
      PG_4K:   r = la[24:12];
      PG_8K:   r = {1'b0, la[24:13]};
      PG_16K:  r = {2'b0, la[24:14]};
      default: r = {3'b0, la[24:15]};
    endcase
    return r;
  endfunction

  function automatic logic [OFF_W-1:0] la_off(logic [LA_W-1:0] la, pg_size_e sz);
    logic [OFF_W-1:0] r;
    unique case (sz)
      PG_4K:   r = {3'b0, la[11:0]};
      PG_8K:   r = {2'b0, la[12:0]};
      PG_16K:  r = {1'b0, la[13:0]};
      default: r = la[14:0];
    endcase
    return r;
  endfunction

  function automatic logic [PA_W-1:0] phys_addr(logic [IDX_W-1:0] ppn,
                                                logic [OFF_W-1:0] off,
                                                pg_size_e sz);
    logic [PA_W-1:0] r;
    unique case (sz)
      PG_4K:   r = {3'b0, ppn, off[11:0]};
      PG_8K:   r = {2'b0, ppn, off[12:0]};
      PG_16K:  r = {1'b0, ppn, off[13:0]};
      default: r = {ppn, off[14:0]};
    endcase
    return r;
  endfunction

  function automatic logic perm_ok(logic [1:0] lvl, acc_mode_e m, logic wr);
    logic r;
    unique case (m)
      AM_SUP:  r = 1'b1;
      AM_OS:   r = (lvl[1] == 1'b0) || !wr;
      default: r = (lvl == 2'b00) || ((lvl == 2'b01) && !wr);
    endcase
    return r;
  endfunction

endpackage

// File: rtl/xlate_table.sv
module xlate_table #(
  parameter int NUM_ENT = xlate_pkg::NUM_ENT,
  parameter int ENT_W   = xlate_pkg::ENT_W,
  localparam int IDX_W  = $clog2(NUM_ENT)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en_i,
  input  logic [ENT_W-1:0]                wr_data_i,
  output logic [NUM_ENT-1:0][ENT_W-1:0]   ent_o,
  output logic [NUM_ENT-1:0]              vld_o
);

  logic [IDX_W-1:0] wr_idx;
  assign wr_idx = wr_data_i[IDX_W-1:0];

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_slot
    logic             slot_we;
    logic [ENT_W-1:0] data_q;
    logic             vld_q;
    logic             vld_d;

    assign slot_we = wr_en_i && (wr_idx == IDX_W'(g));

    always_comb begin
      vld_d = vld_q;
      if (slot_we) vld_d = 1'b1;
    end

    // Entry payload: no reset, guarded by the slot valid bit.
    always_ff @(posedge clk) begin
      if (slot_we) data_q <= wr_data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld_q <= 1'b0;
      else        vld_q <= vld_d;
    end

    assign ent_o[g] = data_q;
    assign vld_o[g] = vld_q;
  end

  // R2
  wr_marks_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> vld_o[$past(wr_idx)]);

endmodule

// File: rtl/xlate_match.sv
module xlate_match
  import xlate_pkg::*;
#(
  parameter int NUM_ENT = xlate_pkg::NUM_ENT,
  parameter int ENT_W   = xlate_pkg::ENT_W,
  parameter int LPN_W   = xlate_pkg::LPN_W
) (
  input  logic [NUM_ENT-1:0][ENT_W-1:0] ent_i,
  input  logic [NUM_ENT-1:0]            vld_i,
  input  pg_size_e                      sz_i,
  input  logic [LPN_W-1:0]              page_i,
  input  acc_mode_e                     mode_i,
  input  logic                          wr_i,
  output logic [NUM_ENT-1:0]            match_o,
  output logic [NUM_ENT-1:0]            hit_o
);

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_cmp
    logic [LPN_W-1:0] slot_lpn;
    logic             unused_b7;

    assign slot_lpn   = ent_lpn(ent_i[g], sz_i);
    assign match_o[g] = vld_i[g] && (slot_lpn == page_i);
    assign hit_o[g]   = match_o[g] &&
                        perm_ok(ent_i[g][LVL_LSB+1:LVL_LSB], mode_i, wr_i);
    assign unused_b7  = ent_i[g][7];
  end

endmodule

// File: rtl/xlate_prio.sv
module xlate_prio #(
  parameter int NUM_ENT = xlate_pkg::NUM_ENT
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_ENT-1:0] req_i,
  output logic [NUM_ENT-1:0] grant_o,
  output logic               any_o
);

  // Isolate the lowest set bit.
  assign grant_o = req_i & (~req_i + NUM_ENT'(1));
  assign any_o   = |req_i;

  // R12
  grant_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));

  // R12
  grant_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_i) |-> (grant_o != '0));

endmodule

// File: rtl/phys_page_xlate.sv
module phys_page_xlate
  import xlate_pkg::*;
#(
  parameter int NUM_ENT = xlate_pkg::NUM_ENT,
  parameter int ENT_W   = xlate_pkg::ENT_W,
  parameter int AW      = 32,
  parameter int PA_W    = xlate_pkg::PA_W,
  localparam int IDX_W  = $clog2(NUM_ENT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tbl_wr_en,
  input  logic [ENT_W-1:0] tbl_wr_addr,
  input  logic [1:0]       cfg_page_sz,
  input  logic             cfg_os_mode,
  input  logic             req_valid,
  input  logic [AW-1:0]    req_addr,
  input  logic             req_word,
  input  logic             req_write,
  input  logic             req_user,
  output logic             rsp_valid,
  output logic             rsp_abort,
  output logic [PA_W-1:0]  rsp_paddr
);

  pg_size_e         sz;
  acc_mode_e        mode;
  logic [LA_W-1:0]  la;
  logic [LPN_W-1:0] page_no;
  logic [OFF_W-1:0] off;
  logic             unused_hi;

  assign sz        = pg_size_e'(cfg_page_sz);
  assign unused_hi = ^req_addr[AW-1:LA_W];

  always_comb begin
    la = req_addr[LA_W-1:0];
    if (req_word) la[1:0] = 2'b00;
  end

  always_comb begin
    if (!req_user)       mode = AM_SUP;
    else if (cfg_os_mode) mode = AM_OS;
    else                 mode = AM_USR;
  end

  assign page_no = la_page(la, sz);
  assign off     = la_off(la, sz);

  logic [NUM_ENT-1:0][ENT_W-1:0] ent;
  logic [NUM_ENT-1:0]            vld;
  logic [NUM_ENT-1:0]            match_vec;
  logic [NUM_ENT-1:0]            hit_vec;
  logic [NUM_ENT-1:0]            grant;
  logic                          any_hit;

  xlate_table #(.NUM_ENT(NUM_ENT), .ENT_W(ENT_W)) u_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (tbl_wr_en),
    .wr_data_i (tbl_wr_addr),
    .ent_o     (ent),
    .vld_o     (vld)
  );

  xlate_match #(.NUM_ENT(NUM_ENT), .ENT_W(ENT_W), .LPN_W(LPN_W)) u_match (
    .ent_i   (ent),
    .vld_i   (vld),
    .sz_i    (sz),
    .page_i  (page_no),
    .mode_i  (mode),
    .wr_i    (req_write),
    .match_o (match_vec),
    .hit_o   (hit_vec)
  );

  xlate_prio #(.NUM_ENT(NUM_ENT)) u_prio (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   (hit_vec),
    .grant_o (grant),
    .any_o   (any_hit)
  );

  // One-hot AND-OR select of the winning slot.
  logic [ENT_W-1:0] sel_ent;
  always_comb begin
    sel_ent = '0;
    for (int i = 0; i < NUM_ENT; i++) begin
      sel_ent = sel_ent | (ent[i] & {ENT_W{grant[i]}});
    end
  end

  logic [IDX_W-1:0] sel_ppn;
  logic [PA_W-1:0]  pa_calc;
  assign sel_ppn = ent_ppn(sel_ent, sz);
  assign pa_calc = phys_addr(sel_ppn, off, sz);

  // Response register: next state, then flops.
  logic            valid_d, abort_d;
  logic [PA_W-1:0] pa_d;
  logic            valid_q, abort_q;
  logic [PA_W-1:0] pa_q;

  always_comb begin
    valid_d = req_valid;
    abort_d = abort_q;
    pa_d    = pa_q;
    if (req_valid) begin
      abort_d = !any_hit;
      if (any_hit) pa_d = pa_calc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      abort_q <= 1'b0;
      pa_q    <= '0;
    end else begin
      valid_q <= valid_d;
      abort_q <= abort_d;
      pa_q    <= pa_d;
    end
  end

  assign rsp_valid = valid_q;
  assign rsp_abort = abort_q;
  assign rsp_paddr = pa_q;

  // R13
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R13
  rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  // R13
  miss_aborts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !(|hit_vec)) |=> rsp_abort);

  // R9
  sup_match_granted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_user && (|match_vec)) |=> !rsp_abort);

  // R8
  word_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_word && any_hit) |=> (rsp_paddr[1:0] == 2'b00));

endmodule

// File: tb/phys_page_xlate_bench.sv
module phys_page_xlate_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tbl_wr_en;
  logic [22:0] tbl_wr_addr;
  logic [1:0]  cfg_page_sz;
  logic        cfg_os_mode;
  logic        req_valid;
  logic [31:0] req_addr;
  logic        req_word;
  logic        req_write;
  logic        req_user;
  logic        rsp_valid;
  logic        rsp_abort;
  logic [21:0] rsp_paddr;

  always #(CLK_PERIOD/2) clk = ~clk;

  phys_page_xlate u_phys_page_xlate (
    .clk         (clk),
    .rst_n       (rst_n),
    .tbl_wr_en   (tbl_wr_en),
    .tbl_wr_addr (tbl_wr_addr),
    .cfg_page_sz (cfg_page_sz),
    .cfg_os_mode (cfg_os_mode),
    .req_valid   (req_valid),
    .req_addr    (req_addr),
    .req_word    (req_word),
    .req_write   (req_write),
    .req_user    (req_user),
    .rsp_valid   (rsp_valid),
    .rsp_abort   (rsp_abort),
    .rsp_paddr   (rsp_paddr)
  );

  logic [22:0] m_ent [128];
  bit          m_vld [128];
  int          n_chk  = 0;
  int          n_fail = 0;
  bit          finished = 1'b0;

  function automatic logic [6:0] b_ppn(logic [22:0] e, int sz);
    case (sz)
      0:       return e[6:0];
      1:       return {e[0], e[6:1]};
      2:       return {e[1:0], e[6:2]};
      default: return {e[1], e[2], e[0], e[6:3]};
    endcase
  endfunction

  function automatic logic [12:0] b_lpn(logic [22:0] e, int sz);
    case (sz)
      0:       return {e[11:10], e[22:12]};
      1:       return 13'({e[11:10], e[22:13]});
      2:       return 13'({e[11:10], e[22:14]});
      default: return 13'({e[11:10], e[22:15]});
    endcase
  endfunction

  function automatic bit b_perm(logic [1:0] lvl, bit user, bit os, bit wr);
    if (!user) return 1'b1;
    if (os)    return (lvl[1] == 1'b0) || !wr;
    return (lvl == 2'b00) || ((lvl == 2'b01) && !wr);
  endfunction

  // Returns {abort, paddr}.
  function automatic logic [22:0] b_expect(logic [31:0] a, bit word, bit wr,
                                           bit user, bit os, int sz);
    logic [24:0] la;
    logic [12:0] pg;
    logic [24:0] off;
    int          sh;
    la = a[24:0];
    if (word) la[1:0] = 2'b00;
    sh  = 12 + sz;
    pg  = 13'(la >> sh);
    off = la & ((25'd1 << sh) - 25'd1);
    for (int i = 0; i < 128; i++) begin
      if (m_vld[i] && (b_lpn(m_ent[i], sz) == pg) &&
          b_perm(m_ent[i][9:8], user, os, wr))
        return {1'b0, 22'((25'(b_ppn(m_ent[i], sz)) << sh) | off)};
    end
    return {1'b1, 22'd0};
  endfunction

  task automatic report(string tag, bit ok, string act, string exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %s expected %s", tag, act, exp);
    end
  endtask

  task automatic do_write(logic [22:0] a);
    tbl_wr_en   = 1'b1;
    tbl_wr_addr = a;
    @(negedge clk);
    tbl_wr_en   = 1'b0;
    m_ent[a[6:0]] = a;
    m_vld[a[6:0]] = 1'b1;
  endtask

  task automatic lookup_exp(string tag, logic [31:0] a, bit word, bit wr, bit user,
                            bit os, int sz, bit exp_ab, logic [21:0] exp_pa);
    bit ok;
    cfg_page_sz = 2'(sz);
    cfg_os_mode = os;
    req_addr    = a;
    req_word    = word;
    req_write   = wr;
    req_user    = user;
    req_valid   = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    ok = (rsp_valid === 1'b1) && (rsp_abort === exp_ab) &&
         (exp_ab || (rsp_paddr === exp_pa));
    report(tag, ok,
           $sformatf("valid=%0b abort=%0b pa=%h", rsp_valid, rsp_abort, rsp_paddr),
           $sformatf("valid=1 abort=%0b pa=%h", exp_ab, exp_pa));
  endtask

  task automatic lookup(string tag, logic [31:0] a, bit word, bit wr, bit user,
                        bit os, int sz);
    logic [22:0] e;
    e = b_expect(a, word, wr, user, os, sz);
    lookup_exp(tag, a, word, wr, user, os, sz, e[22], e[21:0]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL R13: actual run still busy expected run complete (watchdog)");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  string sz_tag [4] = '{"R3", "R4", "R5", "R6"};

  initial begin
    logic [22:0] eA, eB, eC3, eC10, eD, eE, eF, eG;
    int unused_seed;

    for (int i = 0; i < 128; i++) begin
      m_vld[i] = 1'b0;
      m_ent[i] = '0;
    end
    rst_n = 1'b0;
    tbl_wr_en = 1'b0; tbl_wr_addr = '0; cfg_page_sz = '0; cfg_os_mode = 1'b0;
    req_valid = 1'b0; req_addr = '0; req_word = 1'b0; req_write = 1'b0; req_user = 1'b0;
    repeat (3) @(negedge clk);
    report("R13 reset", (rsp_valid === 1'b0) && (rsp_abort === 1'b0),
           $sformatf("valid=%0b abort=%0b", rsp_valid, rsp_abort), "valid=0 abort=0");
    rst_n = 1'b1;
    @(negedge clk);

    // R1: empty table aborts
    lookup_exp("R1 empty", 32'h0000_0000, 1'b0, 1'b0, 1'b0, 1'b0, 0, 1'b1, 22'd0);
    lookup_exp("R1 empty 32K", 32'h0123_4567, 1'b1, 1'b1, 1'b0, 1'b0, 3, 1'b1, 22'd0);

    // R3, R7, R8: 4 KB slot 5
    eA = {11'h123, 2'b01, 2'b00, 1'b0, 7'h05};
    do_write(eA);
    lookup_exp("R3 R7 byte", {7'h55, 13'h0923, 12'hABF}, 1'b0, 1'b0, 1'b0, 1'b0, 0,
               1'b0, {3'b0, 7'h05, 12'hABF});
    lookup_exp("R8 word", {7'h00, 13'h0923, 12'hABF}, 1'b1, 1'b1, 1'b0, 1'b0, 0,
               1'b0, {3'b0, 7'h05, 12'hABC});
    lookup_exp("R7 high bits", {7'h7F, 13'h0923, 12'h001}, 1'b0, 1'b0, 1'b0, 1'b0, 0,
               1'b0, {3'b0, 7'h05, 12'h001});

    // R6: 32 KB slot 0x0D
    eB = {8'hC3, 3'b101, 2'b10, 2'b00, 1'b0, 7'h0D};
    do_write(eB);
    lookup_exp("R6 literal", {7'h00, 10'h2C3, 15'h1234}, 1'b0, 1'b0, 1'b0, 1'b0, 3,
               1'b0, {7'h31, 15'h1234});

    // R5: 16 KB slot 0x46
    eF = {9'h1F0, 2'b00, 2'b01, 2'b00, 1'b0, 7'h46};
    do_write(eF);
    lookup_exp("R5 literal", {7'h00, 2'b01, 9'h1F0, 14'h0ABC}, 1'b0, 1'b0, 1'b0, 1'b0, 2,
               1'b0, {1'b0, 7'h51, 14'h0ABC});

    // R4: 8 KB slot 0x07
    eG = {10'h2A5, 1'b0, 2'b11, 2'b00, 1'b0, 7'h07};
    do_write(eG);
    lookup_exp("R4 literal", {7'h00, 2'b11, 10'h2A5, 13'h1FFF}, 1'b0, 1'b0, 1'b0, 1'b0, 1,
               1'b0, {2'b0, 7'h43, 13'h1FFF});

    // R12 and R2: two slots share a logical page
    eC3  = {11'h055, 2'b00, 2'b00, 1'b0, 7'h03};
    eC10 = {11'h055, 2'b00, 2'b00, 1'b0, 7'h0A};
    do_write(eC10);
    do_write(eC3);
    lookup_exp("R12 lowest wins", {7'h00, 13'h0055, 12'h010}, 1'b0, 1'b0, 1'b0, 1'b0, 0,
               1'b0, {3'b0, 7'h03, 12'h010});
    eC3 = {11'h055, 2'b00, 2'b10, 1'b0, 7'h03};
    do_write(eC3);
    lookup_exp("R2 R12 rewrite skips denied", {7'h00, 13'h0055, 12'h010}, 1'b0, 1'b0,
               1'b1, 1'b0, 0, 1'b0, {3'b0, 7'h0A, 12'h010});
    lookup_exp("R2 rewrite sup", {7'h00, 13'h0055, 12'h010}, 1'b0, 1'b1,
               1'b0, 1'b0, 0, 1'b0, {3'b0, 7'h03, 12'h010});

    // R9, R10, R11: level 10 slot 0x14
    eD = {11'h3AA, 2'b11, 2'b10, 1'b0, 7'h14};
    do_write(eD);
    lookup_exp("R9 sup write lvl10", {7'h00, 2'b11, 11'h3AA, 12'h444}, 1'b0, 1'b1, 1'b0,
               1'b1, 0, 1'b0, {3'b0, 7'h14, 12'h444});
    lookup_exp("R10 os read lvl10", {7'h00, 2'b11, 11'h3AA, 12'h444}, 1'b0, 1'b0, 1'b1,
               1'b1, 0, 1'b0, {3'b0, 7'h14, 12'h444});
    lookup_exp("R10 os write lvl10", {7'h00, 2'b11, 11'h3AA, 12'h444}, 1'b0, 1'b1, 1'b1,
               1'b1, 0, 1'b1, 22'd0);
    lookup_exp("R11 user read lvl10", {7'h00, 2'b11, 11'h3AA, 12'h444}, 1'b0, 1'b0, 1'b1,
               1'b0, 0, 1'b1, 22'd0);

    // R10, R11: level 01 slot 0x21
    eE = {11'h2BB, 2'b00, 2'b01, 1'b0, 7'h21};
    do_write(eE);
    lookup_exp("R11 user read lvl01", {7'h00, 2'b00, 11'h2BB, 12'h008}, 1'b0, 1'b0, 1'b1,
               1'b0, 0, 1'b0, {3'b0, 7'h21, 12'h008});
    lookup_exp("R11 user write lvl01", {7'h00, 2'b00, 11'h2BB, 12'h008}, 1'b0, 1'b1, 1'b1,
               1'b0, 0, 1'b1, 22'd0);
    lookup_exp("R10 os write lvl01", {7'h00, 2'b00, 11'h2BB, 12'h008}, 1'b0, 1'b1, 1'b1,
               1'b1, 0, 1'b0, {3'b0, 7'h21, 12'h008});

    // R13: no request, no response
    @(negedge clk);
    report("R13 idle", rsp_valid === 1'b0, $sformatf("valid=%0b", rsp_valid), "valid=0");

    // Constrained random phase
    unused_seed = $urandom(32'h5EED_1234);
    for (int i = 0; i < 48; i++) do_write(23'($urandom));
    for (int n = 0; n < 500; n++) begin
      int          sz, j;
      logic [31:0] a;
      bit          user, os, wr, word;
      if (n % 50 == 49) begin
        for (int k = 0; k < 4; k++) do_write(23'($urandom));
      end
      sz   = int'($urandom % 4);
      user = 1'($urandom);
      os   = 1'($urandom);
      wr   = 1'($urandom);
      word = 1'($urandom);
      a    = $urandom;
      j    = int'($urandom % 128);
      if (m_vld[j] && ($urandom % 4 != 0)) begin
        a[24:0] = 25'((25'(b_lpn(m_ent[j], sz)) << (12 + sz)) |
                      (25'(a[14:0]) & ((25'd1 << (12 + sz)) - 25'd1)));
      end
      lookup($sformatf("%s R9 R10 R11 R12 random", sz_tag[sz]), a, word, wr, user, os, sz);
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule